// File: doc/BRIEF.md
# Store Path with Deferred Array Write

This block is the store side of a small direct-mapped data cache in which every store crosses two pipeline stages. In the first stage the store's tag is checked. The second stage writes the data of the store in front of it into the data array. The two stages overlap: the tag check of the store now being accepted happens in the same cycle as the array update of the store accepted before it. A one-entry holding register sits between the stages. It keeps the address, data, byte enables and a valid flag of the store that has passed its tag check but has not yet been written.

Loads share the lookup port with stores but never enter the holding register. A load that addresses the held word gets the held bytes merged over the array bytes, so the delay of the array write cannot be seen. On a miss, whether by a load or a store, the held store is first written to the array. The stage is then empty while an external agent fetches the line. That agent returns the line together with a one-cycle done pulse. The requester keeps its request asserted and it completes once the line is present. A line is one data word, so the cache is addressed by word.

Top module: `store_defer_cache`

## Requirements
- R1: After reset every line is invalid: fill_req and rsp_valid are low, and req_ready is low for any address.
- R2: The low IDX_W bits of req_addr select the line and the remaining upper bits are the tag. req_ready is high in a cycle only when the selected line is valid with a matching tag and no fill is in progress. A request completes at a rising edge where req_valid and req_ready are both high.
- R3: A completed store gives no response (rsp_valid stays low). Its address, data and byte enables enter the holding register. The held store is written into the array at the edge where the next store completes or where a miss starts, and not before.
- R4: A completed load drives rsp_valid high in the following cycle. rsp_data is the addressed word, with the held bytes taking the place of the array bytes wherever the held byte enables are set and the held address equals the load address.
- R5: A load leaves the holding register unchanged, so a store followed by loads to other addresses is still returned correctly by a later load to its own address.
- R6: On a miss, req_ready stays low. From the next cycle fill_req is high with fill_addr equal to the missing address. Both hold until the cycle of fill_done, and req_ready is low until the cycle after fill_done. The holding register is empty for the whole fill.
- R7: At fill_done the line named by fill_addr takes fill_data and becomes valid with its tag. A held request to that address then completes.
- R8: A held store is written to the array before a fill can replace its line. A store followed by a miss on another line remains readable, and a fill of a conflicting line on the same index returns exactly fill_data.
- R9: A store changes only the byte lanes whose req_be bit is set (bit i covers data bits 8i+7 to 8i). Back-to-back partial stores to one word combine lane by lane, with the later store taking priority.
- R10: Stores may complete in consecutive cycles to different addresses, and every one of them is later read back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| req_ready | output | 1 | Request completes this edge when high with req_valid |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Load data |
| fill_req | output | 1 | Line fetch in progress |
| fill_addr | output | ADDR_W | Address of the line to fetch |
| fill_done | input | 1 | One-cycle pulse, line delivered |
| fill_data | input | DATA_W | Line contents, valid with fill_done |

## Verification
The bench builds the block with ADDR_W of 8, IDX_W of 3 and DATA_W of 32. That gives eight lines, thirty-two tags per index and four byte lanes. With so few lines, same-index conflicts arise from small address steps. This exercises eviction while a store is held, and four lanes make complementary partial stores easy to tell apart. Each fill comes back two cycles after the request and carries a data pattern computed from the address, so every load result can be predicted from a cache model kept in the bench.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_FILL = 1'b1
   } sdc_state_e;
endpackage

// File: rtl/sdc_tag_store.sv
module sdc_tag_store #(
   parameter int IDX_W = 3,
   parameter int TAG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             hit,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   localparam int SETS = 1 << IDX_W;

   logic [SETS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < SETS; i++) tag_q[i] <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
         tag_q[wr_idx] <= wr_tag;
      end
   end

   assign hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

   // R7
   install_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/sdc_data_array.sv
module sdc_data_array #(
   parameter int IDX_W  = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              we,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W/8-1:0] wr_be,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int SETS = 1 << IDX_W;
   localparam int BE_W = DATA_W / 8;

   logic [DATA_W-1:0] mem_q [SETS];

   assign rd_data = mem_q[rd_idx];

   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SETS; i++) mem_q[i][8*b +: 8] <= '0;
         end else if (we && wr_be[b]) begin
            mem_q[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
         end
      end

      // R9
      lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && !wr_be[b]) |=> (mem_q[$past(wr_idx)][8*b +: 8] == $past(mem_q[wr_idx][8*b +: 8])));
   end
endmodule

// File: rtl/sdc_defer_reg.sv
module sdc_defer_reg #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_en,
   input  logic                clr_en,
   input  logic [ADDR_W-1:0]   in_addr,
   input  logic [DATA_W-1:0]   in_data,
   input  logic [DATA_W/8-1:0] in_be,
   output logic                pend_valid,
   output logic [ADDR_W-1:0]   pend_addr,
   output logic [DATA_W-1:0]   pend_data,
   output logic [DATA_W/8-1:0] pend_be,
   input  logic [ADDR_W-1:0]   look_addr,
   input  logic [DATA_W-1:0]   base_data,
   output logic [DATA_W-1:0]   fwd_data
);
   localparam int BE_W = DATA_W / 8;

   logic match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_addr  <= '0;
         pend_data  <= '0;
         pend_be    <= '0;
      end else if (load_en) begin
         pend_valid <= 1'b1;
         pend_addr  <= in_addr;
         pend_data  <= in_data;
         pend_be    <= in_be;
      end else if (clr_en) begin
         pend_valid <= 1'b0;
      end
   end

   assign match = pend_valid && (pend_addr == look_addr);

   for (genvar b = 0; b < BE_W; b++) begin : g_fwd
      assign fwd_data[8*b +: 8] = (match && pend_be[b]) ? pend_data[8*b +: 8]
                                                         : base_data[8*b +: 8];
   end

   // R3
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && !load_en && !clr_en) |=>
         (pend_valid && $stable(pend_addr) && $stable(pend_data) && $stable(pend_be)));
endmodule

// File: rtl/store_defer_cache.sv
module store_defer_cache
   import sdc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 3,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_store,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   output logic                req_ready,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_data,
   output logic                fill_req,
   output logic [ADDR_W-1:0]   fill_addr,
   input  logic                fill_done,
   input  logic [DATA_W-1:0]   fill_data
);
   localparam int TAG_W = ADDR_W - IDX_W;
   localparam int BE_W  = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_index
      $error("IDX_W must lie between 1 and ADDR_W-1");
   end

   sdc_state_e state_q;
   logic [ADDR_W-1:0] fill_addr_q;

   logic hit, in_run, acc, st_hit, miss_start, fill_install, commit;
   logic arr_we;
   logic [IDX_W-1:0]  arr_idx;
   logic [BE_W-1:0]   arr_be;
   logic [DATA_W-1:0] arr_wdata, arr_rdata, fwd_data;
   logic              pend_valid;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] pend_data;
   logic [BE_W-1:0]   pend_be;

   // stage 1: tag check
   sdc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (req_addr[IDX_W-1:0]),
      .rd_tag (req_addr[ADDR_W-1:IDX_W]),
      .hit    (hit),
      .wr_en  (fill_install),
      .wr_idx (fill_addr_q[IDX_W-1:0]),
      .wr_tag (fill_addr_q[ADDR_W-1:IDX_W])
   );

   assign in_run       = (state_q == ST_RUN);
   assign req_ready    = in_run && hit;
   assign acc          = req_valid && req_ready;
   assign st_hit       = acc && req_store;
   assign miss_start   = req_valid && in_run && !hit;
   assign fill_install = (state_q == ST_FILL) && fill_done;
   assign commit       = pend_valid && (st_hit || miss_start);

   // stage 2: one write port shared by deferred commit and line install
   assign arr_we    = commit || fill_install;
   assign arr_idx   = commit ? pend_addr[IDX_W-1:0] : fill_addr_q[IDX_W-1:0];
   assign arr_be    = commit ? pend_be : {BE_W{1'b1}};
   assign arr_wdata = commit ? pend_data : fill_data;

   sdc_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (req_addr[IDX_W-1:0]),
      .rd_data (arr_rdata),
      .we      (arr_we),
      .wr_idx  (arr_idx),
      .wr_be   (arr_be),
      .wr_data (arr_wdata)
   );

   sdc_defer_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_defer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (st_hit),
      .clr_en     (miss_start),
      .in_addr    (req_addr),
      .in_data    (req_wdata),
      .in_be      (req_be),
      .pend_valid (pend_valid),
      .pend_addr  (pend_addr),
      .pend_data  (pend_data),
      .pend_be    (pend_be),
      .look_addr  (req_addr),
      .base_data  (arr_rdata),
      .fwd_data   (fwd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_RUN;
         fill_addr_q <= '0;
         rsp_valid   <= 1'b0;
         rsp_data    <= '0;
      end else begin
         rsp_valid <= acc && !req_store;
         if (acc && !req_store) rsp_data <= fwd_data;
         case (state_q)
            ST_RUN: if (miss_start) begin
               state_q     <= ST_FILL;
               fill_addr_q <= req_addr;
            end
            ST_FILL: if (fill_done) state_q <= ST_RUN;
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign fill_req  = (state_q == ST_FILL);
   assign fill_addr = fill_addr_q;

   // R6
   fill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> (!pend_valid && !req_ready));

   // R6
   fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !fill_done) |=> (fill_req && $stable(fill_addr)));

   // R3
   store_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_hit |=> (pend_valid && pend_addr == $past(req_addr) && !rsp_valid));

   // R3
   overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_hit && pend_valid) |-> arr_we);

   // R4
   load_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_store) |=> rsp_valid);

   // R5
   load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_store) |=> ($stable(pend_valid) && $stable(pend_addr) && $stable(pend_data)));
endmodule

// File: tb/store_defer_cache_tb.sv
module store_defer_cache_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 8;
   localparam int IDX_W      = 3;
   localparam int DATA_W     = 32;
   localparam int SETS       = 1 << IDX_W;
   localparam int FILL_LAT   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_store = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic [3:0]        req_be = '0;
   logic req_ready, rsp_valid, fill_req;
   logic [DATA_W-1:0] rsp_data;
   logic [ADDR_W-1:0] fill_addr;
   logic fill_done = 1'b0;
   logic [DATA_W-1:0] fill_data = '0;

   int n_chk = 0, n_bad = 0;

   logic                     m_v   [SETS];
   logic [ADDR_W-IDX_W-1:0]  m_tag [SETS];
   logic [DATA_W-1:0]        m_d   [SETS];

   store_defer_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .fill_req(fill_req), .fill_addr(fill_addr), .fill_done(fill_done),
      .fill_data(fill_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
      return {a, ~a, a ^ 8'h5A, 8'hC3};
   endfunction

   function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                                input logic [DATA_W-1:0] nw,
                                                input logic [3:0] be);
      logic [DATA_W-1:0] r = old;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // fill agent
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         fill_done = 1'b0;
         if (fill_req) begin
            cnt++;
            if (cnt == FILL_LAT) begin
               fill_done = 1'b1;
               fill_data = pat(fill_addr);
               cnt = 0;
            end
         end
      end
   end

   // one request, miss handled; entered and left at a falling edge
   task automatic access(input bit st, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input logic [3:0] be, input string rq);
      int idx = int'(a[IDX_W-1:0]);
      bit exp_miss = !(m_v[idx] && m_tag[idx] == a[ADDR_W-1:IDX_W]);
      int guard = 0;
      req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = d; req_be = be;
      #1;
      check(req_ready == !exp_miss, "R2 hit/miss", 32'(req_ready), 32'(!exp_miss));
      if (exp_miss) begin
         @(negedge clk); #1;
         check(fill_req && fill_addr == a && !req_ready, "R6 fill request",
               {23'd0, fill_req, fill_addr}, {23'd1, 1'b1, a});
         while (!req_ready && guard < 50) begin
            @(negedge clk); #1; guard++;
         end
         check(guard == FILL_LAT, "R6 stall length", guard, FILL_LAT);
         check(req_ready, "R7 request completes after fill", 32'(req_ready), 32'd1);
         m_v[idx] = 1'b1; m_tag[idx] = a[ADDR_W-1:IDX_W]; m_d[idx] = pat(a);
      end
      @(posedge clk);
      @(negedge clk);
      if (st) begin
         m_d[idx] = merge(m_d[idx], d, be);
         check(!rsp_valid, "R3 no response to store", 32'(rsp_valid), 32'd0);
      end else begin
         check(rsp_valid && rsp_data == m_d[idx], rq, rsp_data, m_d[idx]);
      end
   endtask

   task automatic idle();
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      #1;
      check(!fill_req && !rsp_valid && !req_ready, "R1 reset state",
            {29'd0, fill_req, rsp_valid, req_ready}, 32'd0);
   endtask

   task automatic t_store_load();
      access(1'b1, 8'h11, 32'hDEAD_BEEF, 4'hF, "R3");
      access(1'b0, 8'h11, '0, 4'h0, "R4 forwarded load");
      idle();
   endtask

   task automatic t_partial();
      access(1'b1, 8'h22, 32'h1111_1111, 4'b0101, "R9");
      access(1'b1, 8'h22, 32'h2222_2222, 4'b1010, "R9");
      access(1'b1, 8'h22, 32'h3333_3333, 4'b0001, "R9");
      access(1'b0, 8'h22, '0, 4'h0, "R9 lane merge");
      idle();
   endtask

   task automatic t_burst();
      for (int i = 0; i < 4; i++) access(1'b0, 8'(8'h40 + i), '0, 4'h0, "R4 warm load");
      for (int i = 0; i < 4; i++)
         access(1'b1, 8'(8'h40 + i), 32'(32'hA000_0000 + i * 32'h0101), 4'hF, "R10");
      for (int i = 3; i >= 0; i--) access(1'b0, 8'(8'h40 + i), '0, 4'h0, "R10 readback");
      idle();
   endtask

   task automatic t_load_between();
      access(1'b1, 8'h41, 32'h5555_AAAA, 4'b1100, "R5");
      access(1'b0, 8'h42, '0, 4'h0, "R5 other load");
      access(1'b0, 8'h43, '0, 4'h0, "R5 other load");
      access(1'b0, 8'h41, '0, 4'h0, "R5 held store still seen");
      idle();
   endtask

   task automatic t_flush_other();
      access(1'b1, 8'h44, 32'h0BAD_F00D, 4'hF, "R8");
      access(1'b0, 8'h95, '0, 4'h0, "R8 miss other index");
      access(1'b0, 8'h44, '0, 4'h0, "R8 store survives fill");
      idle();
   endtask

   task automatic t_conflict();
      access(1'b1, 8'h46, 32'hFACE_CAFE, 4'hF, "R8");
      access(1'b0, 8'h86, '0, 4'h0, "R8 conflicting fill exact");
      access(1'b0, 8'h86, '0, 4'h0, "R8 conflicting line stable");
      access(1'b1, 8'h07, 32'h7777_0000, 4'b1100, "R7 store miss");
      access(1'b0, 8'h07, '0, 4'h0, "R7 store over fill data");
      idle();
   endtask

   initial begin
      for (int i = 0; i < SETS; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_d[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      @(negedge clk);
      t_store_load();
      t_partial();
      t_burst();
      t_load_between();
      t_flush_other();
      t_conflict();
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule